// File: doc/BRIEF.md
# Serial-In Latched Display Driver Core

This block is the digital core of a twelve-output display driver. Bits arrive one at a time on a serial input and move through a twelve-stage shift chain. The last stage is brought out as a serial output, so a second driver can be chained behind the first to form a longer chain. A level-sensitive strobe copies the chain into a bank of latches. The latches drive the twelve output lines through a blanking gate. When blanking is asserted, every line is forced to its off (low) level and the latch contents stay as they are.

Inside the chip the shift clock is the system clock qualified by `shift_valid`. A beat is taken on every rising edge at which `shift_valid` is high. The core always accepts data, so there is no ready signal and no back-pressure: a sender may present one beat per cycle without stalling. Strobe and blanking are plain level controls. The synchronous reset exists for simulation start-up and clears both the chain and the latches.

Output line k (k = 1..12) is `drv_out[k-1]` and shows chain stage k. Stage 1 is the stage nearest the serial input.

Top module: `disp_shift_driver`

## Requirements
- R1: With `rst` high at a rising edge, the shift chain and the latches are cleared to zero. After reset, `drv_out` and `ser_out` read 0, whether strobe is high or low.
- R2: At a rising edge with `shift_valid` high, `ser_in` enters stage 1 (`drv_out[0]` position) and every stage k takes the old value of stage k-1. After 12 such beats, the first bit sits in stage 12 (`drv_out[11]`).
- R3: At a rising edge with `shift_valid` low, every stage keeps its value, whatever the level of `ser_in`.
- R4: `ser_out` always equals stage 12. Chaining `ser_out` of one instance into `ser_in` of a second instance makes a 24-stage chain, in which the second instance holds the older 12 bits.
- R5: While `strobe` is high, each latch is transparent. With blanking low, `drv_out` equals the chain contents in the same cycle, including cycles in which the chain is shifting.
- R6: While `strobe` is low, the latches hold the chain contents from the last cycle in which strobe was high. Shifting does not change `drv_out`.
- R7: While `blank` is high, all 12 bits of `drv_out` are 0, whatever the latch or chain contents.
- R8: Blanking does not alter the latches. In the first cycle after `blank` falls with strobe low, `drv_out` equals the values latched before the blanking pulse, even if the chain has since changed.
- R9: With strobe held high (latches bypassed) and blank high during data entry, `drv_out` stays 0 while bits ripple in. It shows the final chain contents once blank falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; rising edge is the shift event |
| rst | input | 1 | Synchronous reset, clears chain and latches |
| shift_valid | input | 1 | Qualifies a serial beat at this edge; always accepted |
| ser_in | input | 1 | Serial data bit |
| strobe | input | 1 | High: latches transparent; low: latches hold |
| blank | input | 1 | High: all output lines forced low |
| ser_out | output | 1 | Stage 12 of the chain, for cascading |
| drv_out | output | 12 | Output lines; bit k-1 is stage k |

## Verification
The hardest situation to reach from the ports is one that proves blanking left the latches alone. That proof needs the chain and the latches to hold different data at the moment blanking is released. The stimulus therefore loads and strobes one pattern, shifts fresh bits in with strobe low, and only then pulses blanking. Cascading is exercised with two instances chained through `ser_out`, and both output buses are compared with a 24-bit reference chain kept in the bench.

// File: rtl/disp_drv_pkg.sv
`timescale 1ns/1ps
package disp_drv_pkg;
  localparam int DEFAULT_LINES = 12;

  typedef struct packed {
    logic take;
    logic bit_val;
  } ser_beat_t;

  function automatic logic [0:0] line_off_level();
    return 1'b0;
  endfunction
endpackage

// File: rtl/shift_chain.sv
`timescale 1ns/1ps
module shift_chain
  import disp_drv_pkg::*;
#(
  parameter int STAGES = DEFAULT_LINES
) (
  input  logic              clk,
  input  logic              rst,
  input  ser_beat_t         beat,
  output logic [STAGES-1:0] stage_q,
  output logic              tail
);
  localparam int LAST = STAGES - 1;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    logic feed;
    if (i == 0) begin : g_head
      assign feed = beat.bit_val;
    end else begin : g_body
      assign feed = stage_q[i-1];
    end
    always_ff @(posedge clk) begin
      if (rst)            stage_q[i] <= 1'b0;
      else if (beat.take) stage_q[i] <= feed;
    end
  end

  assign tail = stage_q[LAST];

  // R2: a qualified beat moves every stage by one and admits the new bit
  assert_shift_R2: assert property (@(posedge clk) disable iff (rst)
    beat.take |=> (stage_q[0] == $past(beat.bit_val)) &&
                  (stage_q[LAST:1] == $past(stage_q[LAST-1:0])));

  // R3: without a beat the chain holds
  assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !beat.take |=> $stable(stage_q));
endmodule

// File: rtl/latch_bank.sv
`timescale 1ns/1ps
module latch_bank
  import disp_drv_pkg::*;
#(
  parameter int LINES = DEFAULT_LINES
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             strobe,
  input  logic [LINES-1:0] chain_d,
  output logic [LINES-1:0] view
);
  logic [LINES-1:0] held_q;

  for (genvar i = 0; i < LINES; i++) begin : g_cell
    always_ff @(posedge clk) begin
      if (rst)         held_q[i] <= 1'b0;
      else if (strobe) held_q[i] <= chain_d[i];
    end
    assign view[i] = strobe ? chain_d[i] : held_q[i];
  end

  // R5: the value seen while transparent is what the cell keeps
  assert_capture_R5: assert property (@(posedge clk) disable iff (rst)
    strobe |=> held_q == $past(chain_d));

  // R6: with strobe low across two cycles, the visible value does not move
  assert_keep_R6: assert property (@(posedge clk) disable iff (rst)
    !strobe |=> (strobe || $stable(view)));
endmodule

// File: rtl/blank_gate.sv
`timescale 1ns/1ps
module blank_gate
  import disp_drv_pkg::*;
#(
  parameter int LINES = DEFAULT_LINES
) (
  input  logic             blank,
  input  logic [LINES-1:0] level_d,
  output logic [LINES-1:0] line_q
);
  for (genvar i = 0; i < LINES; i++) begin : g_line
    assign line_q[i] = blank ? line_off_level() : level_d[i];
  end
endmodule

// File: rtl/disp_shift_driver.sv
`timescale 1ns/1ps
module disp_shift_driver
  import disp_drv_pkg::*;
#(
  parameter int NUM_LINES = DEFAULT_LINES
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 shift_valid,
  input  logic                 ser_in,
  input  logic                 strobe,
  input  logic                 blank,
  output logic                 ser_out,
  output logic [NUM_LINES-1:0] drv_out
);
  ser_beat_t            beat;
  logic [NUM_LINES-1:0] chain_q;
  logic [NUM_LINES-1:0] latch_view;

  assign beat.take    = shift_valid;
  assign beat.bit_val = ser_in;

  shift_chain #(.STAGES(NUM_LINES)) u_chain (
    .clk     (clk),
    .rst     (rst),
    .beat    (beat),
    .stage_q (chain_q),
    .tail    (ser_out)
  );

  latch_bank #(.LINES(NUM_LINES)) u_latch (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .chain_d (chain_q),
    .view    (latch_view)
  );

  blank_gate #(.LINES(NUM_LINES)) u_gate (
    .blank   (blank),
    .level_d (latch_view),
    .line_q  (drv_out)
  );

  // R8: releasing blank exposes the untouched latch contents
  assert_unblank_R8: assert property (@(posedge clk) disable iff (rst)
    (!blank && $past(blank) && !strobe && $past(!strobe) && $past(!rst))
      |-> drv_out == $past(latch_view));
endmodule

// File: tb/sim_disp_shift_driver.sv
`timescale 1ns/1ps
module sim_disp_shift_driver;
  localparam int N = 12;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst = 1'b1, sv = 1'b0, sd = 1'b0, stb = 1'b0, blk = 1'b0;
  logic so0, so1;
  logic [N-1:0] o0, o1;

  int checks = 0;
  int fails  = 0;

  logic [2*N-1:0] m_sr  = '0;
  logic [N-1:0]   m_lat0 = '0;
  logic [N-1:0]   m_lat1 = '0;

  disp_shift_driver #(.NUM_LINES(N)) u0 (
    .clk(clk), .rst(rst), .shift_valid(sv), .ser_in(sd), .strobe(stb),
    .blank(blk), .ser_out(so0), .drv_out(o0));

  disp_shift_driver #(.NUM_LINES(N)) u1 (
    .clk(clk), .rst(rst), .shift_valid(sv), .ser_in(so0), .strobe(stb),
    .blank(blk), .ser_out(so1), .drv_out(o1));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [N-1:0] exp_lines(logic [N-1:0] sr, logic [N-1:0] lat,
                                             logic s, logic b);
    if (b) return '0;
    return s ? sr : lat;
  endfunction

  // one cycle: drive after the edge, check mid-cycle, advance the model
  task automatic cyc(logic r, logic v, logic d, logic s, logic b,
                     string req_lines, string req_tail);
    @(posedge clk);
    #1;
    rst = r; sv = v; sd = d; stb = s; blk = b;
    #2;
    if (!r) begin
      chk(req_lines, 32'(o0), 32'(exp_lines(m_sr[N-1:0], m_lat0, s, b)));
      chk(req_lines, 32'(o1), 32'(exp_lines(m_sr[2*N-1:N], m_lat1, s, b)));
      chk(req_tail, {30'd0, so1, so0}, {30'd0, m_sr[2*N-1], m_sr[N-1]});
    end
    if (r) begin
      m_sr = '0; m_lat0 = '0; m_lat1 = '0;
    end else begin
      if (s) begin
        m_lat0 = m_sr[N-1:0];
        m_lat1 = m_sr[2*N-1:N];
      end
      if (v) m_sr = {m_sr[2*N-2:0], d};
    end
  endtask

  initial begin
    #1000000;
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5A17));
    for (int i = 0; i < 3; i++) cyc(1, 0, 0, 0, 0, "", "");

    // R1: cleared state, strobe low and high
    cyc(0, 0, 0, 0, 0, "R1", "R1");
    cyc(0, 0, 0, 1, 0, "R1", "R1");

    // R2 / R4 / R6: 24 random bits through the cascade, strobe low
    for (int i = 0; i < 2*N; i++) cyc(0, 1, 1'($urandom), 0, 0, "R6", "R4");
    // R5: strobe exposes both buses; then R2 check of held result
    cyc(0, 0, 0, 1, 0, "R5", "R2");
    cyc(0, 0, 0, 0, 0, "R2", "R4");

    // R3: no beats while ser_in toggles; strobe shows unchanged chain
    for (int i = 0; i < 6; i++) cyc(0, 0, 1'(i), 0, 0, "R3", "R3");
    cyc(0, 0, 1, 1, 0, "R3", "R3");

    // R2 directed: single one walks to stage 12 and out
    cyc(1, 0, 0, 0, 0, "", "");
    cyc(0, 1, 1, 0, 0, "R2", "R2");
    for (int i = 0; i < N; i++) cyc(0, 1, 0, 1, 0, "R2", "R4");
    for (int i = 0; i < N; i++) cyc(0, 1, 1, 1, 0, "R5", "R4");

    // R7 / R8: latch a pattern, shift new bits strobe low, pulse blank
    for (int i = 0; i < N; i++) cyc(0, 1, 1'(i % 3 == 0), 0, 0, "R6", "R4");
    cyc(0, 0, 0, 1, 0, "R5", "R4");
    for (int i = 0; i < 5; i++) cyc(0, 1, 1'(~i[0]), 0, 0, "R6", "R4");
    for (int i = 0; i < 4; i++) cyc(0, 1, 1'($urandom), 0, 1, "R7", "R4");
    cyc(0, 0, 0, 0, 0, "R8", "R8");
    cyc(0, 0, 0, 1, 1, "R7", "R7");
    cyc(0, 0, 0, 0, 0, "R8", "R8");

    // R9: bypass mode, blank during entry
    for (int i = 0; i < N; i++) cyc(0, 1, 1'($urandom), 1, 1, "R9", "R4");
    cyc(0, 0, 0, 1, 0, "R9", "R9");

    // mixed random traffic
    for (int i = 0; i < 400; i++)
      cyc(0, 1'($urandom), 1'($urandom), 1'($urandom % 4 == 0),
          1'($urandom % 5 == 0), "R5", "R2");

    // R1: reset in the middle of loaded data
    cyc(1, 0, 0, 0, 0, "", "");
    cyc(0, 0, 0, 0, 0, "R1", "R1");
    cyc(0, 0, 0, 1, 0, "R1", "R1");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule